// File: doc/BRIEF.md
# Hysteretic Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two single-cycle edge strobes, one from the reference divider and one from the feedback divider, both already synchronised to a fast measurement clock. For each pair of edges it counts how many measurement-clock ticks separate the earlier edge from the later one, and it reports that count as the phase error of the comparison.

An active-high lock flag rises only after a run of consecutive comparisons whose error is below a fine threshold. The length of that run is chosen by a precision input: a short run or a longer, stricter one. Once the flag is high it tolerates errors up to a larger coarse threshold and falls only when one comparison reaches that coarse threshold. Because the two thresholds differ, the flag does not chatter when the error sits near either threshold. Changing the precision input starts qualification again from scratch.

Top module: `pll_lock_watch`

## Requirements
- R1: While reset is asserted and on release, `lock_o` is 0 and `err_o` is 0.
- R2: The phase error is the number of measurement-clock ticks from the first-arriving strobe to the other strobe. Either strobe may arrive first, and both in the same cycle gives 0. `err_o` takes the new value one clock after the cycle in which the closing strobe is sampled.
- R3: If the other strobe does not arrive within MAX_TICKS ticks, or the first strobe repeats before the other arrives, the comparison ends with `err_o` equal to MAX_TICKS (31 by default).
- R4: With `strict_i` = 0, `lock_o` rises after 3 consecutive comparisons whose error is below FINE_TICKS (4 by default). It rises one clock after `err_o` shows the third such error.
- R5: With `strict_i` = 1, `lock_o` rises only after 5 consecutive such comparisons, and it stays low after 4.
- R6: While unlocked, a comparison with error at or above FINE_TICKS resets the run of good comparisons to zero.
- R7: Once locked, comparisons with error below COARSE_TICKS (7 by default) keep `lock_o` high, including errors between the two thresholds.
- R8: Once locked, a comparison with error at or above COARSE_TICKS drops `lock_o` one clock after `err_o` shows it.
- R9: A change of `strict_i` clears `lock_o` and the run of good comparisons on the next clock, so a complete new run is needed to lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb_i | input | 1 | One-cycle strobe marking a reference edge |
| fb_stb_i | input | 1 | One-cycle strobe marking a feedback edge |
| strict_i | input | 1 | Run-length select: 0 needs 3 good comparisons, 1 needs 5 |
| lock_o | output | 1 | Lock flag, active high |
| err_o | output | ERR_W | Phase error of the last finished comparison, in ticks |

## Verification
The assertions assume that each strobe is a clean single-cycle pulse in the measurement-clock domain, and that `strict_i` changes only while no comparison is in progress. Under these conditions a comparison-done event and a precision change never compete in the same cycle. The bench drives every strobe for exactly one clock at the falling edge. It spaces edge pairs so that each comparison closes before the next one opens, and it changes the precision input only between pairs. The saturation case is the only one in which a pair is left open, and the bench then waits out the whole window before it sends more stimulus.

// File: rtl/plw_pkg.sv
package plw_pkg;

  // Error strictly below the fine threshold counts toward lock.
  function automatic logic below_fine(input int err, input int fine);
    return err < fine;
  endfunction

  // Error at or above the coarse threshold breaks an existing lock.
  function automatic logic at_coarse(input int err, input int coarse);
    return err >= coarse;
  endfunction

  // Required run length for the selected precision.
  function automatic int run_needed(input logic strict, input int loose_n, input int strict_n);
    return strict ? strict_n : loose_n;
  endfunction

endpackage

// File: rtl/plw_phase_meter.sv
module plw_phase_meter #(
  parameter int MAX_TICKS = 31,
  parameter int ERR_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb_i,
  input  logic             fb_stb_i,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);

  localparam logic [ERR_W-1:0] MAX_V = ERR_W'(MAX_TICKS);

  logic             wait_q;
  logic             ref_first_q;
  logic [ERR_W-1:0] cnt_q;

  // Named events for checking
  logic tie_ev, open_ev, close_ev, repeat_ev, timeout_ev;

  assign tie_ev     = !wait_q && ref_stb_i && fb_stb_i;
  assign open_ev    = !wait_q && (ref_stb_i ^ fb_stb_i);
  assign close_ev   = wait_q && (ref_first_q ? fb_stb_i : ref_stb_i);
  assign repeat_ev  = wait_q && !close_ev && (ref_first_q ? ref_stb_i : fb_stb_i);
  assign timeout_ev = wait_q && !close_ev && !repeat_ev && (cnt_q == MAX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q      <= 1'b0;
      ref_first_q <= 1'b0;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      err_o       <= '0;
    end else begin
      done_o <= tie_ev | close_ev | repeat_ev | timeout_ev;
      if (tie_ev)                      err_o <= '0;
      else if (close_ev)               err_o <= cnt_q;
      else if (repeat_ev | timeout_ev) err_o <= MAX_V;

      if (open_ev) begin
        wait_q      <= 1'b1;
        ref_first_q <= ref_stb_i;
        cnt_q       <= ERR_W'(1);
      end else if (close_ev | repeat_ev | timeout_ev) begin
        wait_q <= 1'b0;
      end else if (wait_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: coincident edges give zero error on the next clock
  assert_tie_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tie_ev |=> (done_o && err_o == '0));

  // R3: an unanswered window ends saturated
  assert_timeout_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (done_o && err_o == MAX_V));

  // R3: a repeated first edge also ends saturated
  assert_repeat_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_ev |=> (done_o && err_o == MAX_V));

endmodule

// File: rtl/plw_classify.sv
module plw_classify #(
  parameter int FINE_TICKS   = 4,
  parameter int COARSE_TICKS = 7,
  parameter int ERR_W        = 5
) (
  input  logic [ERR_W-1:0] err_i,
  output logic             good_o,
  output logic             bad_o
);
  import plw_pkg::*;

  always_comb begin
    good_o = below_fine(int'(err_i), FINE_TICKS);
    bad_o  = at_coarse(int'(err_i), COARSE_TICKS);
  end

  // Hysteresis: a measurement is never both good and bad
  always_comb begin
    assert_disjoint_R7: assert (!(good_o && bad_o));
  end

endmodule

// File: rtl/plw_streak.sv
module plw_streak #(
  parameter int LOOSE_CNT  = 3,
  parameter int STRICT_CNT = 5,
  parameter int CNT_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic good_i,
  input  logic bad_i,
  input  logic sel_i,
  output logic lock_o
);
  import plw_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STRICT_CNT);

  logic             sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_chg;
  logic [CNT_W:0]   need;
  logic [CNT_W:0]   next_run;

  assign sel_chg  = (sel_i != sel_q);
  assign need     = (CNT_W+1)'(run_needed(sel_i, LOOSE_CNT, STRICT_CNT));
  assign next_run = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (sel_chg) begin
        lock_o <= 1'b0;
        cnt_q  <= '0;
      end else if (done_i) begin
        if (lock_o) begin
          if (bad_i) begin
            lock_o <= 1'b0;
            cnt_q  <= '0;
          end else if (!good_i) begin
            cnt_q <= '0;
          end
        end else if (good_i) begin
          if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
          if (next_run >= need) lock_o <= 1'b1;
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  // R4: lock only rises after a good comparison
  assert_rise_on_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(done_i && good_i));

  // R8: a coarse error drops an existing lock
  assert_drop_on_coarse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && done_i && bad_i && !sel_chg) |=> !lock_o);

  // R7: without a coarse error or precision change, lock holds
  assert_hold_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !sel_chg && !(done_i && bad_i)) |=> lock_o);

  // R9: a precision change clears flag and run
  assert_sel_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> (!lock_o && cnt_q == '0));

endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch #(
  parameter int FINE_TICKS   = 4,
  parameter int COARSE_TICKS = 7,
  parameter int MAX_TICKS    = 31,
  parameter int LOOSE_CNT    = 3,
  parameter int STRICT_CNT   = 5,
  localparam int ERR_W       = $clog2(MAX_TICKS + 1),
  localparam int CNT_W       = $clog2(STRICT_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb_i,
  input  logic             fb_stb_i,
  input  logic             strict_i,
  output logic             lock_o,
  output logic [ERR_W-1:0] err_o
);

  logic meas_done;
  logic meas_good;
  logic meas_bad;

  plw_phase_meter #(
    .MAX_TICKS (MAX_TICKS),
    .ERR_W     (ERR_W)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb_i (ref_stb_i),
    .fb_stb_i  (fb_stb_i),
    .done_o    (meas_done),
    .err_o     (err_o)
  );

  plw_classify #(
    .FINE_TICKS   (FINE_TICKS),
    .COARSE_TICKS (COARSE_TICKS),
    .ERR_W        (ERR_W)
  ) u_class (
    .err_i  (err_o),
    .good_o (meas_good),
    .bad_o  (meas_bad)
  );

  plw_streak #(
    .LOOSE_CNT  (LOOSE_CNT),
    .STRICT_CNT (STRICT_CNT),
    .CNT_W      (CNT_W)
  ) u_streak (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (meas_done),
    .good_i (meas_good),
    .bad_i  (meas_bad),
    .sel_i  (strict_i),
    .lock_o (lock_o)
  );

  // R1: flag is clear whenever reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!lock_o && err_o == '0));

endmodule

// File: tb/test_pll_lock_watch.sv
module test_pll_lock_watch;

  localparam int FINE   = 4;
  localparam int COARSE = 7;
  localparam int MAXT   = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_stb = 1'b0;
  logic       fb_stb = 1'b0;
  logic       strict = 1'b0;
  logic       lock;
  logic [4:0] err;

  int n_chk = 0;
  int n_bad = 0;
  bit model_lock;
  int model_run;

  always #2 clk = ~clk;

  pll_lock_watch i_pll_lock_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb_i (ref_stb),
    .fb_stb_i  (fb_stb),
    .strict_i  (strict),
    .lock_o    (lock),
    .err_o     (err)
  );

  typedef struct packed {
    logic       fb_first;
    logic [7:0] gap;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 8'd1},   // R2 ref first
    '{1'b1, 8'd2},   // R2 fb first
    '{1'b0, 8'd0},   // R2 tie, third good -> R4 lock
    '{1'b0, 8'd5},   // R7 between thresholds, hold
    '{1'b1, 8'd6},   // R7 hold
    '{1'b0, 8'd8},   // R8 coarse drop
    '{1'b0, 8'd3},   // good run 1
    '{1'b1, 8'd9},   // R6 run reset
    '{1'b0, 8'd1},   // run 1
    '{1'b1, 8'd1},   // run 2
    '{1'b0, 8'd2}    // run 3 -> R4 lock
  };

  task automatic check(input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_lock = 1'b0;
    model_run  = 0;
    @(negedge clk);
  endtask

  task automatic pair(input bit fb_first, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_stb = 1'b1; fb_stb = 1'b1;
    end else if (fb_first) fb_stb = 1'b1;
    else ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0; fb_stb = 1'b0;
    if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      if (fb_first) ref_stb = 1'b1;
      else fb_stb = 1'b1;
      @(negedge clk);
      ref_stb = 1'b0; fb_stb = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic void model_step(input int e);
    int need;
    need = strict ? 5 : 3;
    if (model_lock) begin
      if (e >= COARSE) begin model_lock = 1'b0; model_run = 0; end
      else if (e >= FINE) model_run = 0;
    end else if (e < FINE) begin
      model_run++;
      if (model_run >= need) model_lock = 1'b1;
    end else model_run = 0;
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check(int'(lock), 0, "R1 lock in reset");
    check(int'(err), 0, "R1 err in reset");
    do_reset();
    check(int'(lock), 0, "R1 lock after release");

    // Vector table: R2 R4 R6 R7 R8
    foreach (VECS[i]) begin
      pair(VECS[i].fb_first, int'(VECS[i].gap));
      model_step(int'(VECS[i].gap));
      check(int'(err), int'(VECS[i].gap), $sformatf("R2 err vec %0d", i));
      check(int'(lock), int'(model_lock), $sformatf("lock R4 R6 R7 R8 vec %0d", i));
    end

    // R3 timeout saturation
    do_reset();
    @(negedge clk);
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    repeat (MAXT + 4) @(negedge clk);
    check(int'(err), MAXT, "R3 timeout saturation");
    check(int'(lock), 0, "R3 no lock on saturation");

    // R3 repeated first edge
    pair(1'b1, 3);
    check(int'(err), 3, "R2 fb first gap 3");
    @(negedge clk);
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    repeat (2) @(negedge clk);
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(err), MAXT, "R3 repeated edge saturation");

    // R5 strict run of five
    strict = 1'b1;
    do_reset();
    for (int k = 0; k < 4; k++) pair(1'b0, 1);
    check(int'(lock), 0, "R5 no lock after four");
    pair(1'b1, 2);
    check(int'(lock), 1, "R5 lock after five");

    // R9 precision change clears
    @(negedge clk);
    strict = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(lock), 0, "R9 lock cleared by select change");
    pair(1'b0, 1);
    pair(1'b0, 1);
    check(int'(lock), 0, "R9 run restarted, two not enough");
    pair(1'b0, 1);
    check(int'(lock), 1, "R9 relock after three");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule